// File: doc/BRIEF.md
# Nine-Bit Multidrop UART

This block is a serial transmitter and receiver whose frames carry a ninth data bit, for links where one master talks to several slaves over a shared line. The ninth bit marks the kind of frame: 1 for an address frame and 0 for a data frame. A master first sends an address frame to pick its target slaves, then sends the data frames for them.

The receiver oversamples the line on a 16x baud tick supplied from outside. It confirms the start bit at mid-bit, samples nine bits at their centres and checks the stop bit. An address-only control input filters which frames reach software. While it is high, only frames whose ninth bit is 1 raise the receive flag, so data meant for other slaves is dropped without disturbing the last byte received. Software lowers the control once it has matched its own address, takes the following data frames, and raises it again when the message ends.

Top module: `nine_bit_uart`

## Requirements
- R1: While idle, `tx_line` is 1. After `tx_start`, the transmitter sends eleven bit periods of 16 ticks each, in this order: a start bit of 0, `tx_data` least significant bit first, `tx_bit9`, then a stop bit of 1.
- R2: `tx_busy` is high for the whole frame. `tx_done` pulses for one cycle as the stop bit ends, in the same cycle that `tx_busy` falls.
- R3: With `addr_only` low, every frame whose stop bit samples as 1 sets `rx_ready` and loads `rx_data` and `rx_bit9`, whatever its ninth bit is.
- R4: With `addr_only` high, a correctly framed frame sets `rx_ready` only if its ninth bit is 1.
- R5: A frame dropped by the address filter leaves `rx_data`, `rx_bit9` and `rx_ready` unchanged.
- R6: A frame whose stop bit samples as 0 pulses `frame_err` for one cycle. It never sets `rx_ready` and never changes `rx_data`.
- R7: A low level on `rx_line` that has gone high again by the middle of the start bit is not taken as a frame. It raises neither `rx_ready` nor `frame_err`.
- R8: A high `rx_clear` clears `rx_ready`. If a frame qualifies in the same cycle, the flag is set instead.
- R9: After reset, `tx_line` is 1, and `tx_busy`, `tx_done`, `rx_ready`, `rx_bit9`, `frame_err` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| addr_only | input | 1 | Address-only filter enable, written by software |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit to transmit |
| tx_start | input | 1 | Starts a frame when the transmitter is idle |
| tx_busy | output | 1 | A frame is being sent |
| tx_done | output | 1 | One-cycle pulse at the end of the stop bit |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input |
| rx_clear | input | 1 | Clears the receive flag |
| rx_data | output | 8 | Last byte accepted |
| rx_bit9 | output | 1 | Ninth bit of the last frame accepted |
| rx_ready | output | 1 | Receive flag |
| frame_err | output | 1 | One-cycle pulse when a stop bit samples as 0 |

## Verification
In loopback, the main path runs through a table of frames that covers both values of the ninth bit under both settings of the filter. A data frame sent with the filter on tells a correct filter apart from a missing or inverted one. The next row, an address frame, shows that the filter lets it through. Bytes with alternating bits, all ones and all zeros expose bit-order and shift faults on both sides. Hand-built frames on the receive line show that a bad stop bit is reported and that a short glitch is rejected, and holding the clear strobe high through a reception shows that setting the flag wins over clearing it.

// File: rtl/nine_bit_uart.sv
module nine_bit_uart #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          addr_only,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  input  logic          tx_start,
  output logic          tx_busy,
  output logic          tx_done,
  output logic          tx_line,
  input  logic          rx_line,
  input  logic          rx_clear,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_ready,
  output logic          frame_err
);
  localparam int SW = $clog2(OVS);
  localparam int FW = DW + 3;
  localparam int LW = $clog2(FW + 1);
  localparam int CW = $clog2(DW + 1);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] MID  = SW'(OVS / 2 - 1);

  // transmitter
  logic [FW-1:0] tx_sh;
  logic [LW-1:0] tx_left;
  logic [SW-1:0] tx_sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '1;
      tx_left <= '0;
      tx_sub  <= '0;
      tx_busy <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (!tx_busy && tx_start) begin
        tx_sh   <= {1'b1, tx_bit9, tx_data, 1'b0};
        tx_left <= LW'(FW);
        tx_sub  <= '0;
        tx_busy <= 1'b1;
      end else if (tx_busy && tick16) begin
        tx_sub <= (tx_sub == LAST) ? '0 : tx_sub + 1'b1;
        if (tx_sub == LAST) begin
          tx_sh   <= {1'b1, tx_sh[FW-1:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == LW'(1)) begin
            tx_busy <= 1'b0;
            tx_done <= 1'b1;
          end
        end
      end
    end
  end

  assign tx_line = tx_busy ? tx_sh[0] : 1'b1;

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;
  rx_state_t     rx_st;
  logic [1:0]    rx_sync;
  logic          rx_s;
  logic [SW-1:0] rx_sub;
  logic [CW-1:0] rx_cnt;
  logic [DW:0]   rx_sh;
  logic          stop_pt, rx_set;

  assign rx_s    = rx_sync[1];
  assign stop_pt = (rx_st == RX_STOP) && tick16 && (rx_sub == LAST);
  assign rx_set  = stop_pt && rx_s && (!addr_only || rx_sh[DW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync   <= 2'b11;
      rx_st     <= RX_IDLE;
      rx_sub    <= '0;
      rx_cnt    <= '0;
      rx_sh     <= '0;
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      rx_ready  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_sync   <= {rx_sync[0], rx_line};
      frame_err <= 1'b0;
      if (rx_set) begin
        rx_ready <= 1'b1;
        rx_data  <= rx_sh[DW-1:0];
        rx_bit9  <= rx_sh[DW];
      end else if (rx_clear) begin
        rx_ready <= 1'b0;
      end
      if (tick16) begin
        case (rx_st)
          RX_IDLE:
            if (!rx_s) begin
              rx_st  <= RX_START;
              rx_sub <= '0;
            end
          RX_START:
            if (rx_sub == MID) begin
              rx_sub <= '0;
              rx_cnt <= '0;
              rx_st  <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              rx_sub <= rx_sub + 1'b1;
            end
          RX_BITS:
            if (rx_sub == LAST) begin
              rx_sub <= '0;
              rx_sh  <= {rx_s, rx_sh[DW:1]};
              if (rx_cnt == CW'(DW)) rx_st <= RX_STOP;
              else rx_cnt <= rx_cnt + 1'b1;
            end else begin
              rx_sub <= rx_sub + 1'b1;
            end
          RX_STOP:
            if (rx_sub == LAST) begin
              rx_sub    <= '0;
              rx_st     <= RX_IDLE;
              frame_err <= !rx_s;
            end else begin
              rx_sub <= rx_sub + 1'b1;
            end
          default: rx_st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

module nine_bit_uart_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_only,
  input logic          tx_busy,
  input logic          tx_done,
  input logic          tx_line,
  input logic          rx_clear,
  input logic [DW-1:0] rx_data,
  input logic          rx_bit9,
  input logic          rx_ready,
  input logic          frame_err
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);
  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_busy && $past(tx_busy)));
  p_busy_falls_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> tx_done);
  p_addr_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_ready) && $past(addr_only)) |-> rx_bit9);
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_ready);
  p_err_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($stable(rx_data) && !$rose(rx_ready)));
  p_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rx_clear));
endmodule

bind nine_bit_uart nine_bit_uart_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .addr_only(addr_only), .tx_busy(tx_busy),
  .tx_done(tx_done), .tx_line(tx_line), .rx_clear(rx_clear),
  .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ready(rx_ready),
  .frame_err(frame_err)
);

// File: tb/test_nine_bit_uart.sv
module test_nine_bit_uart;
  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic       addr_only = 1'b0, tx_bit9 = 1'b0, tx_start = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_drv = 1'b1, loop_en = 1'b1, rx_clear = 1'b0;
  logic       tx_busy, tx_done, tx_line, rx_line, rx_bit9, rx_ready, frame_err;
  logic [7:0] rx_data;
  int         n_chk = 0, n_bad = 0;
  int         done_cnt = 0, err_cnt = 0, rise_cnt = 0;
  logic       ready_q = 1'b0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;
  assign rx_line = loop_en ? tx_line : rx_drv;

  always @(posedge clk) begin
    tick16  <= rst_n ? ~tick16 : 1'b0;
    ready_q <= rx_ready;
    if (tx_done) done_cnt++;
    if (frame_err) err_cnt++;
    if (rx_ready && !ready_q) rise_cnt++;
  end

  nine_bit_uart i_nine_bit_uart (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .addr_only(addr_only),
    .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_start(tx_start),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_line(tx_line),
    .rx_line(rx_line), .rx_clear(rx_clear), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_ready(rx_ready), .frame_err(frame_err)
  );

  // [10:3] byte, [2] ninth bit, [1] addr_only, [0] flag expected
  localparam logic [10:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b0, 1'b1},
    {8'h3C, 1'b1, 1'b0, 1'b1},
    {8'h5A, 1'b0, 1'b1, 1'b0},
    {8'h81, 1'b1, 1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b1, 1'b1},
    {8'h96, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); rx_clear = 1'b1;
    @(negedge clk); rx_clear = 1'b0;
  endtask

  // sends through the transmitter and checks each bit at mid-period (32 clocks per bit)
  task automatic send_tx(logic [7:0] d, logic b9);
    logic [10:0] bits;
    int d0;
    bits = {1'b1, b9, d, 1'b0};
    d0 = done_cnt;
    @(negedge clk);
    tx_data = d; tx_bit9 = b9; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int i = 0; i < 11; i++) begin
      clks(15);
      check($sformatf("R1 frame bit %0d", i), {15'd0, tx_line}, {15'd0, bits[i]});
      if (i == 10) check("R2 busy in stop bit", {15'd0, tx_busy}, 16'd1);
      clks(17);
    end
    for (int k = 0; k < 100 && tx_busy; k++) @(negedge clk);
    clks(4);
    check("R2 one done pulse per frame", 16'(done_cnt - d0), 16'd1);
    check("R1 idle line high", {15'd0, tx_line}, 16'd1);
  endtask

  task automatic drive_rx(logic [7:0] d, logic b9, logic stopb);
    logic [10:0] bits;
    bits = {stopb, b9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); rx_drv = bits[i];
      clks(31);
    end
    @(negedge clk); rx_drv = 1'b1;
    clks(40);
  endtask

  initial begin
    logic [7:0] exp_d;
    logic       exp_b9;
    int         e0, r0;
    exp_d = 8'h00; exp_b9 = 1'b0;
    clks(3);
    check("R9 tx_line", {15'd0, tx_line}, 16'd1);
    check("R9 tx_busy/tx_done", {14'd0, tx_busy, tx_done}, 16'd0);
    check("R9 rx flags", {13'd0, rx_ready, rx_bit9, frame_err}, 16'd0);
    check("R9 rx_data", {8'd0, rx_data}, 16'd0);
    rst_n = 1'b1;
    clks(4);

    for (int v = 0; v < 8; v++) begin
      clear_flag();
      addr_only = VEC[v][1];
      send_tx(VEC[v][10:3], VEC[v][2]);
      if (VEC[v][0]) begin
        exp_d = VEC[v][10:3]; exp_b9 = VEC[v][2];
      end
      check(VEC[v][1] ? "R4 flag with filter on" : "R3 flag with filter off",
            {15'd0, rx_ready}, {15'd0, VEC[v][0]});
      check(VEC[v][0] ? "R3 byte and ninth bit" : "R5 data held when dropped",
            {7'd0, rx_bit9, rx_data}, {7'd0, exp_b9, exp_d});
    end

    // R5: a dropped frame leaves a pending flag set
    addr_only = 1'b1;
    send_tx(8'h42, 1'b0);
    check("R5 pending flag kept", {15'd0, rx_ready}, 16'd1);
    check("R5 data kept", {7'd0, rx_bit9, rx_data}, {7'd0, exp_b9, exp_d});

    // R6: stop bit 0
    loop_en = 1'b0; addr_only = 1'b0;
    clear_flag();
    e0 = err_cnt;
    drive_rx(8'h77, 1'b1, 1'b0);
    check("R6 one frame_err pulse", 16'(err_cnt - e0), 16'd1);
    check("R6 no flag", {15'd0, rx_ready}, 16'd0);
    check("R6 data kept", {8'd0, rx_data}, {8'd0, exp_d});

    // R7: short glitch
    e0 = err_cnt;
    @(negedge clk); rx_drv = 1'b0;
    clks(6);
    rx_drv = 1'b1;
    clks(400);
    check("R7 no flag after glitch", {15'd0, rx_ready}, 16'd0);
    check("R7 no error after glitch", 16'(err_cnt - e0), 16'd0);
    drive_rx(8'hC3, 1'b0, 1'b1);
    check("R7 next frame still taken", {7'd0, rx_ready, rx_data}, {7'd0, 1'b1, 8'hC3});

    // R8: clear held high across a reception
    clear_flag();
    check("R8 clear resets flag", {15'd0, rx_ready}, 16'd0);
    r0 = rise_cnt;
    @(negedge clk); rx_clear = 1'b1;
    drive_rx(8'h1E, 1'b1, 1'b1);
    rx_clear = 1'b0;
    check("R8 set wins over clear", 16'(rise_cnt - r0), 16'd1);
    check("R8 flag cleared afterwards", {15'd0, rx_ready}, 16'd0);
    check("R8 byte loaded", {7'd0, rx_bit9, rx_data}, {7'd0, 1'b1, 8'h1E});

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule